// File: doc/BRIEF.md
# Vector Element Predicate Mask Generator

This block turns a compact predicate specification into a per-element enable mask for a vector loop of up to 64 elements. A single mode input chooses between two kinds of predicate source. In integer mode the mask comes from one of three 64-bit integer registers, which are presented on input ports. The register can be used directly, inverted, or as an index that enables exactly one element. In condition mode every element tests one bit of its own 4-bit condition field. The fields come from a flattened array of 128 fields, and the run starts at a base field index.

Two channels are decoded side by side. One is the destination mask and the other is the source mask used for twin predication. Each channel has its own 3-bit code, and both share the mode input, so the two channels never mix integer and condition sources. All lanes at or above the vector length are forced off. The loop controller pulses `start` before the element operations begin. Both masks are captured at that edge and then held, so later writes to the condition fields or the registers during the loop do not disturb them. `mask_ready` pulses in the cycle that follows `start`.

Top module: `pm_mask_gen`

## Requirements
- R1: With `cr_mode`=0 and code 3'b000, every element below the effective vector length is enabled.
- R2: With `cr_mode`=0 and code 3'b001, only element i where i equals `reg_a` is enabled. A `reg_a` value of 64 or more enables no element.
- R3: With `cr_mode`=0, the upper two code bits pick the register: 01 selects `reg_a`, 10 selects `reg_b`, 11 selects `reg_c`. Code bit 0 chooses the sense: 0 enables element i when bit i of the register is 1, and 1 enables it when that bit is 0.
- R4: With `cr_mode`=1, code bits [2:1] pick one condition bit inside a field: 00 is LT (field bit 3), 01 is GT (bit 2), 10 is EQ (bit 1) and 11 is SO (bit 0). Code bit 0 chooses the sense: 0 enables the element when the chosen bit is set, and 1 enables it when the bit is clear.
- R5: In condition mode, element i tests field `cr_base`+i, and field k occupies `cr_fields[4k+3:4k]`. A field index above 127 reads as all zeros.
- R6: `dst_mask` is decoded from `dst_code` and `src_mask` is decoded from `src_code`, independently, under the same `cr_mode`.
- R7: Elements with index at or above `vl` are disabled, and a `vl` above 64 acts as 64. When `vl`=0 both masks are all zero.
- R8: The masks are computed from the inputs present at a clock edge with `start`=1. They appear, with `mask_ready`=1, after that edge, and they stay unchanged until the next start. Input changes in between have no effect.
- R9: After synchronous reset both masks are zero and `mask_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture strobe for both masks |
| cr_mode | input | 1 | 0 selects integer predication, 1 selects condition-field predication |
| vl | input | 7 | Vector length, 0 to 127 (values above 64 act as 64) |
| dst_code | input | 3 | Destination predicate code |
| src_code | input | 3 | Source predicate code |
| reg_a | input | 64 | First integer predicate register (also the one-hot index) |
| reg_b | input | 64 | Second integer predicate register |
| reg_c | input | 64 | Third integer predicate register |
| cr_base | input | 7 | First condition field index for element 0 (normally 32) |
| cr_fields | input | 512 | 128 condition fields of 4 bits each, field k at [4k+3:4k] |
| dst_mask | output | 64 | Captured destination enable mask |
| src_mask | output | 64 | Captured source enable mask |
| mask_ready | output | 1 | One-cycle pulse after a capture |

## Verification
Length clipping and predicate decoding act on the same lane in the same cycle. The bench provokes this with random vector lengths from 0 to 80 combined with every code, so lanes just below and just above the boundary are decoded and then cut. A second coincidence is a start edge followed at once by changes to the registers and condition fields. The bench changes every source in the cycle after capture and then checks that both masks are bit-identical to the values predicted for the captured inputs. Condition runs are placed so that they cross field 127, which mixes real fields and zero-read fields in one mask.

// File: rtl/pm_pkg.sv
package pm_pkg;

    // Default geometry of the block
    localparam int PM_N_EL   = 64;   // lanes per vector
    localparam int PM_XLEN   = 64;   // integer register width
    localparam int PM_N_CR   = 128;  // condition fields available
    localparam int PM_CR_W   = 4;    // bits per condition field

    // Integer source selector carried in the two upper code bits
    typedef enum logic [1:0] {
        ISRC_FIXED = 2'b00,   // all-on or one-hot index
        ISRC_A     = 2'b01,
        ISRC_B     = 2'b10,
        ISRC_C     = 2'b11
    } isrc_e;

    // Condition bit selector carried in the two upper code bits
    typedef enum logic [1:0] {
        CRB_LT = 2'b00,
        CRB_GT = 2'b01,
        CRB_EQ = 2'b10,
        CRB_SO = 2'b11
    } crbit_e;

    // Decoded view of a 3-bit predicate code
    typedef struct packed {
        logic [1:0] sel;
        logic       inv;
    } pm_code_t;

    // Position of a condition bit inside its 4-bit field
    function automatic logic [1:0] crbit_pos(input crbit_e b);
        case (b)
            CRB_LT:  crbit_pos = 2'd3;
            CRB_GT:  crbit_pos = 2'd2;
            CRB_EQ:  crbit_pos = 2'd1;
            default: crbit_pos = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/pm_len_mask.sv
module pm_len_mask
    import pm_pkg::*;
#(
    parameter int N_EL = PM_N_EL,
    parameter int LW   = $clog2(N_EL + 1)
) (
    input  logic [LW-1:0]   vl,
    output logic [N_EL-1:0] mask
);

    // Lane i is inside the loop when vl exceeds i; vl above N_EL saturates
    for (genvar i = 0; i < N_EL; i++) begin : g_lane
        assign mask[i] = (vl > LW'(i));
    end

endmodule

// File: rtl/pm_int_sel.sv
module pm_int_sel
    import pm_pkg::*;
#(
    parameter int N_EL = PM_N_EL,
    parameter int XLEN = PM_XLEN
) (
    input  logic [2:0]      code,
    input  logic [XLEN-1:0] reg_a,
    input  logic [XLEN-1:0] reg_b,
    input  logic [XLEN-1:0] reg_c,
    output logic [N_EL-1:0] mask
);

    localparam int NB = (XLEN < N_EL) ? XLEN : N_EL;

    pm_code_t          cd;
    isrc_e             src;
    logic [N_EL-1:0]   onehot;
    logic [N_EL-1:0]   raw_a;
    logic [N_EL-1:0]   raw_b;
    logic [N_EL-1:0]   raw_c;

    assign cd  = pm_code_t'(code);
    assign src = isrc_e'(cd.sel);

    // Bring each register to lane width; lanes past the register read 0
    for (genvar i = 0; i < N_EL; i++) begin : g_lane
        if (i < NB) begin : g_in
            assign raw_a[i] = reg_a[i];
            assign raw_b[i] = reg_b[i];
            assign raw_c[i] = reg_c[i];
        end else begin : g_out
            assign raw_a[i] = 1'b0;
            assign raw_b[i] = 1'b0;
            assign raw_c[i] = 1'b0;
        end
        assign onehot[i] = (reg_a == XLEN'(i));
    end

    always_comb begin
        unique case (src)
            ISRC_FIXED: mask = cd.inv ? onehot : {N_EL{1'b1}};
            ISRC_A:     mask = cd.inv ? ~raw_a : raw_a;
            ISRC_B:     mask = cd.inv ? ~raw_b : raw_b;
            default:    mask = cd.inv ? ~raw_c : raw_c;
        endcase
    end

endmodule

// File: rtl/pm_cr_sel.sv
module pm_cr_sel
    import pm_pkg::*;
#(
    parameter int N_EL = PM_N_EL,
    parameter int N_CR = PM_N_CR,
    parameter int CRW  = $clog2(N_CR)
) (
    input  logic [2:0]              code,
    input  logic [CRW-1:0]          base,
    input  logic [N_CR*PM_CR_W-1:0] fields,
    output logic [N_EL-1:0]         mask
);

    localparam int SW = CRW + 2;   // wide enough for base plus lane index

    pm_code_t   cd;
    logic [1:0] pos;

    assign cd  = pm_code_t'(code);
    assign pos = crbit_pos(crbit_e'(cd.sel));

    for (genvar i = 0; i < N_EL; i++) begin : g_lane
        logic [SW-1:0]       idx;
        logic [PM_CR_W-1:0]  fld;
        logic [CRW+1:0]      bp;

        assign idx = SW'(base) + SW'(i);
        assign bp  = {idx[CRW-1:0], 2'b00};

        // Fields beyond the array read as zero
        always_comb begin
            if (idx < SW'(N_CR)) fld = fields[bp +: PM_CR_W];
            else                 fld = '0;
        end

        assign mask[i] = fld[pos] ^ cd.inv;
    end

endmodule

// File: rtl/pm_mask_gen.sv
module pm_mask_gen
    import pm_pkg::*;
#(
    parameter int N_EL = PM_N_EL,
    parameter int XLEN = PM_XLEN,
    parameter int N_CR = PM_N_CR,
    parameter int LW   = $clog2(N_EL + 1),
    parameter int CRW  = $clog2(N_CR)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    cr_mode,
    input  logic [LW-1:0]           vl,
    input  logic [2:0]              dst_code,
    input  logic [2:0]              src_code,
    input  logic [XLEN-1:0]         reg_a,
    input  logic [XLEN-1:0]         reg_b,
    input  logic [XLEN-1:0]         reg_c,
    input  logic [CRW-1:0]          cr_base,
    input  logic [N_CR*PM_CR_W-1:0] cr_fields,
    output logic [N_EL-1:0]         dst_mask,
    output logic [N_EL-1:0]         src_mask,
    output logic                    mask_ready
);

    logic [N_EL-1:0] len_m;

    pm_len_mask #(.N_EL(N_EL), .LW(LW)) u_len (
        .vl   (vl),
        .mask (len_m)
    );

    // Channel 0 is the destination mask, channel 1 the source mask
    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        logic [2:0]      code;
        logic [N_EL-1:0] int_m;
        logic [N_EL-1:0] cr_m;
        logic [N_EL-1:0] nxt;
        logic [N_EL-1:0] q;

        assign code = (ch == 0) ? dst_code : src_code;

        pm_int_sel #(.N_EL(N_EL), .XLEN(XLEN)) u_int (
            .code  (code),
            .reg_a (reg_a),
            .reg_b (reg_b),
            .reg_c (reg_c),
            .mask  (int_m)
        );

        pm_cr_sel #(.N_EL(N_EL), .N_CR(N_CR), .CRW(CRW)) u_cr (
            .code   (code),
            .base   (cr_base),
            .fields (cr_fields),
            .mask   (cr_m)
        );

        assign nxt = (cr_mode ? cr_m : int_m) & len_m;

        always_ff @(posedge clk) begin
            if (rst)        q <= '0;
            else if (start) q <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mask_ready <= 1'b0;
        else     mask_ready <= start;
    end

    assign dst_mask = g_ch[0].q;
    assign src_mask = g_ch[1].q;

    // R7
    mask_len_chk: assert property (@(posedge clk) disable iff (rst)
        $past(start) |-> (((dst_mask | src_mask) >> $past(vl)) == '0));

    // R7
    vl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && $past(vl) == '0) |-> (dst_mask == '0 && src_mask == '0));

    // R1
    all_on_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && !$past(cr_mode) && $past(dst_code) == 3'b000)
        |-> ($countones(dst_mask) == (($past(vl) > LW'(N_EL)) ? N_EL : int'($past(vl)))));

    // R2
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && !$past(cr_mode) && $past(src_code) == 3'b001)
        |-> $onehot0(src_mask));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(dst_mask) && $stable(src_mask)));

    // R8
    ready_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> mask_ready);

    // R8
    ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !mask_ready);

endmodule

// File: tb/sim_pm_mask_gen.sv
module sim_pm_mask_gen;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         cr_mode;
    logic [6:0]   vl;
    logic [2:0]   dst_code;
    logic [2:0]   src_code;
    logic [63:0]  reg_a, reg_b, reg_c;
    logic [6:0]   cr_base;
    logic [511:0] cr_fields;
    logic [63:0]  dst_mask, src_mask;
    logic         mask_ready;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    pm_mask_gen u0 (
        .clk(clk), .rst(rst), .start(start), .cr_mode(cr_mode), .vl(vl),
        .dst_code(dst_code), .src_code(src_code),
        .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
        .cr_base(cr_base), .cr_fields(cr_fields),
        .dst_mask(dst_mask), .src_mask(src_mask), .mask_ready(mask_ready)
    );

    // Reference model written from the requirements
    function automatic logic [63:0] ref_mask(input bit crm, input bit [2:0] code,
            input int len, input logic [63:0] a, input logic [63:0] b,
            input logic [63:0] c, input logic [511:0] cr, input int base);
        logic [63:0] m = '0;
        for (int i = 0; i < 64; i++) begin
            bit en;
            if (i >= len) continue;
            if (!crm) begin
                case (code)
                    3'd0: en = 1'b1;
                    3'd1: en = (a == 64'(i));
                    3'd2: en = a[i];
                    3'd3: en = !a[i];
                    3'd4: en = b[i];
                    3'd5: en = !b[i];
                    3'd6: en = c[i];
                    default: en = !c[i];
                endcase
            end else begin
                int k = base + i;
                logic [3:0] f = (k < 128) ? cr[k*4 +: 4] : 4'h0;
                bit v = f[3 - int'(code[2:1])];
                en = code[0] ? !v : v;
            end
            m[i] = en;
        end
        return m;
    endfunction

    function automatic string req_of(input bit crm, input bit [2:0] code, input int len);
        if (len == 0) return "R7";
        if (crm)      return "R4";
        if (code == 3'd0) return "R1";
        if (code == 3'd1) return "R2";
        return "R3";
    endfunction

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic randomize_sources();
        reg_a = {$urandom(), $urandom()};
        reg_b = {$urandom(), $urandom()};
        reg_c = {$urandom(), $urandom()};
        for (int w = 0; w < 16; w++) cr_fields[w*32 +: 32] = $urandom();
    endtask

    // One capture, then a scramble of every input to confirm the hold
    task automatic run_case(input string tag);
        logic [63:0] ed, es;
        string rd, rs;
        ed = ref_mask(cr_mode, dst_code, int'(vl), reg_a, reg_b, reg_c, cr_fields, int'(cr_base));
        es = ref_mask(cr_mode, src_code, int'(vl), reg_a, reg_b, reg_c, cr_fields, int'(cr_base));
        rd = {tag, req_of(cr_mode, dst_code, int'(vl))};
        rs = {tag, req_of(cr_mode, src_code, int'(vl)), "/R6"};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check64("R8", "ready pulse", 64'(mask_ready), 64'd1);
        check64(rd, "dst", dst_mask, ed);
        check64(rs, "src", src_mask, es);
        randomize_sources();
        cr_mode  = ~cr_mode;
        vl       = 7'($urandom_range(0, 127));
        dst_code = 3'($urandom());
        src_code = 3'($urandom());
        cr_base  = 7'($urandom());
        @(negedge clk);
        check64("R8", "ready low", 64'(mask_ready), 64'd0);
        check64("R8", "dst held", dst_mask, ed);
        check64("R8", "src held", src_mask, es);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; start = 1'b0; cr_mode = 1'b0; vl = '0;
        dst_code = '0; src_code = '0; cr_base = 7'd32;
        randomize_sources();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9
        check64("R9", "reset dst", dst_mask, '0);
        check64("R9", "reset src", src_mask, '0);
        check64("R9", "reset ready", 64'(mask_ready), 64'd0);

        // R7 zero length
        cr_mode = 0; vl = 0; dst_code = 3'd0; src_code = 3'd3;
        run_case("dir ");
        // R1 and R7 saturation above 64
        cr_mode = 0; vl = 7'd100; dst_code = 3'd0; src_code = 3'd0;
        run_case("dir ");
        // R2 index inside and outside range
        cr_mode = 0; vl = 7'd64; dst_code = 3'd1; src_code = 3'd1;
        reg_a = 64'd5;
        run_case("dir ");
        cr_mode = 0; vl = 7'd64; dst_code = 3'd1; src_code = 3'd2;
        reg_a = 64'd70;
        run_case("dir ");
        // R2 index at vl boundary
        cr_mode = 0; vl = 7'd10; dst_code = 3'd1; src_code = 3'd7;
        reg_a = 64'd10;
        run_case("dir ");
        // R3 inverted registers, R6 different codes
        cr_mode = 0; vl = 7'd64; dst_code = 3'd5; src_code = 3'd6;
        run_case("dir ");
        // R4 and R5 default base
        cr_mode = 1; vl = 7'd64; dst_code = 3'd2; src_code = 3'd7;
        cr_base = 7'd32;
        run_case("dir R5 ");
        // R5 run crossing field 127 (clear tests enable zero fields)
        cr_mode = 1; vl = 7'd64; dst_code = 3'd1; src_code = 3'd4;
        cr_base = 7'd120;
        cr_fields = '1;
        run_case("dir R5 ");

        for (int n = 0; n < 400; n++) begin
            cr_mode  = 1'($urandom());
            vl       = 7'($urandom_range(0, 80));
            dst_code = 3'($urandom());
            src_code = 3'($urandom());
            cr_base  = (n % 3 == 0) ? 7'd32 : 7'($urandom());
            randomize_sources();
            if (n % 5 == 0) reg_a = 64'($urandom_range(0, 70));
            run_case("rnd ");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule